// File: doc/BRIEF.md
# Program/Erase Status Word Generator

This block forms the word a flash array returns on a read while an embedded program or erase is running, is suspended, or has ended in failure. A separate timing engine reports what the array is doing through an operation-state code, and pulses a finish strobe that carries the fault flags. From these inputs, the block produces a status word and a ready line. It also produces a select line that tells the surrounding read path whether to drive the status word or normal array data.

Two status modes are available through a one-bit configuration register. In mode 0, the polling bit carries the complement of bit 7 of the last word written, and a clean finish drops straight back to array reads. In mode 1, the polling bit is a plain busy/done flag, and every finish holds the status until an ID-exit command arrives. In both modes, a failed operation holds its fault bits until ID exit. Two toggle bits advance on rising edges of the read strobe rather than on every clock.

Top module: `pe_status_gen`

## Requirements
- R1: The status word uses bit 7 for polling, bit 6 for the busy toggle, bit 5 for the fault bit, bit 3 for the supply fault and bit 2 for the erase toggle. Bits 4, 1 and 0 always read 0. With the configuration at 0, bit 7 reads as the inverse of `last_wr_b7` while programming (`op_state`=1), and as 0 while erasing (`op_state`=2).
- R2: With the configuration at 1, bit 7 reads 0 while programming or erasing. It reads 1 in the held state after a clean finish.
- R3: While programming or erasing, bit 6 inverts once for each rising edge of `rd_strobe`, taking effect the cycle after that edge. Once the operation has ended, bit 6 holds its value.
- R4: Bit 2 inverts on each rising edge of `rd_strobe` while erasing. It also inverts while a suspended operation is read inside its sector (`op_state`=3 or 4 with `in_sector`=1). While programming, bit 2 reads 0.
- R5: When `op_fin` pulses with `fin_limit` or `fin_prot` set, the block sets bit 5. When `op_fin` pulses with `fin_vpp` set, it sets bit 3. In either case the status stays selected with ready high until `id_exit` pulses, in both configurations.
- R6: A clean `op_fin` returns the block to array reads (`sel_status`=0) on the next cycle when the configuration is 0. When the configuration is 1, the status stays selected until `id_exit`.
- R7: With erase suspended (`op_state`=3), a read inside the sector returns bit 7=1, bit 6=1, bit 5=0, bit 3=0, bit 2 toggling, and ready=1. A read outside the sector returns array data (`sel_status`=0).
- R8: With programming suspended (`op_state`=4), a read inside the sector returns bit 6=1, bit 2 toggling, and ready=1. Bit 7 is the inverse of `last_wr_b7` under configuration 0, and 1 under configuration 1. A read outside the sector returns array data.
- R9: `ready` is 0 exactly when `op_state` is 1 or 2.
- R10: `cfg_we` loads `cfg_val` into the configuration. `por` clears the configuration to 0. `rst` leaves the configuration untouched, ignores `cfg_we`, clears any held status, and clears both toggle bits.
- R11: When `op_fin` and `id_exit` pulse in the same cycle, the finish takes effect and the exit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, clears everything |
| rst | input | 1 | Device reset, synchronous, keeps configuration |
| op_state | input | 3 | 0 idle, 1 programming, 2 erasing, 3 erase suspended, 4 program suspended |
| last_wr_b7 | input | 1 | Bit 7 of the last word loaded for programming |
| in_sector | input | 1 | Read address lies in the sector of the active or suspended operation |
| rd_strobe | input | 1 | Read strobe; rising edges advance toggle bits |
| op_fin | input | 1 | One-cycle finish pulse from the timing engine |
| fin_limit | input | 1 | Finish with time-limit overrun |
| fin_prot | input | 1 | Finish due to protected-sector target |
| fin_vpp | input | 1 | Finish due to low programming supply |
| id_exit | input | 1 | ID-exit command pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_val | input | 1 | Configuration value to write |
| status_out | output | STS_W | Status word |
| sel_status | output | 1 | 1: read path takes status_out, 0: array data |
| ready | output | 1 | Ready (1) / busy (0) |

## Verification
The finish pulse and the ID-exit command can fall in the same cycle. If exit were applied after the finish, a fault would be dropped the moment it is reported. A directed case pulses both together with a protect fault, and the constrained random phase draws them independently so that they also coincide with clean finishes and configuration writes. The bench judges the result on the following cycle by whether the status stays selected with bit 5 set, or follows the configuration rule for a clean finish.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

    localparam int BYTE_W   = 8;
    localparam int POS_POLL = 7;
    localparam int POS_TOG  = 6;
    localparam int POS_FLT  = 5;
    localparam int POS_SUP  = 3;
    localparam int POS_ETOG = 2;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_ERASE = 3'd2,
        OP_ESUSP = 3'd3,
        OP_PSUSP = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        HOLD_NONE = 2'd0,
        HOLD_DONE = 2'd1,
        HOLD_FAIL = 2'd2
    } hold_e;

    typedef struct packed {
        logic poll;
        logic tog;
        logic flt;
        logic sup;
        logic etog;
    } sts_t;

    function automatic logic [BYTE_W-1:0] pack_sts(input sts_t s);
        logic [BYTE_W-1:0] w;
        w           = '0;
        w[POS_POLL] = s.poll;
        w[POS_TOG]  = s.tog;
        w[POS_FLT]  = s.flt;
        w[POS_SUP]  = s.sup;
        w[POS_ETOG] = s.etog;
        return w;
    endfunction

    function automatic logic op_running(input op_e op);
        return (op == OP_PROG) || (op == OP_ERASE);
    endfunction

    function automatic logic op_suspended(input op_e op);
        return (op == OP_ESUSP) || (op == OP_PSUSP);
    endfunction

    function automatic logic op_is_prog(input op_e op);
        return (op == OP_PROG) || (op == OP_PSUSP);
    endfunction

endpackage

// File: rtl/pe_rd_toggle.sv
module pe_rd_toggle (
    input  logic clk,
    input  logic por,
    input  logic rst,
    input  logic rd_strobe,
    input  logic adv_busy,
    input  logic adv_erase,
    output logic tog_busy,
    output logic tog_erase
);
    logic rd_q;
    logic rd_rise;

    assign rd_rise = rd_strobe && !rd_q;

    always_ff @(posedge clk) begin
        if (por || rst) begin
            rd_q      <= 1'b0;
            tog_busy  <= 1'b0;
            tog_erase <= 1'b0;
        end else begin
            rd_q <= rd_strobe;
            if (rd_rise && adv_busy)
                tog_busy <= ~tog_busy;
            if (rd_rise && adv_erase)
                tog_erase <= ~tog_erase;
        end
    end

    // R3: busy toggle only moves on a strobe rising edge
    assert_tog_edge_R3: assert property (@(posedge clk) disable iff (por || rst)
        !(rd_strobe && !rd_q) |=> $stable(tog_busy));

    // R3: once nothing is running the busy toggle is frozen
    assert_tog_frozen_R3: assert property (@(posedge clk) disable iff (por || rst)
        !adv_busy |=> $stable(tog_busy));

    // R4: erase toggle frozen when no erase-type read is selected
    assert_etog_frozen_R4: assert property (@(posedge clk) disable iff (por || rst)
        !adv_erase |=> $stable(tog_erase));

endmodule

// File: rtl/pe_hold_ctl.sv
module pe_hold_ctl
    import pe_status_pkg::*;
(
    input  logic  clk,
    input  logic  por,
    input  logic  rst,
    input  op_e   op,
    input  logic  cfg_we,
    input  logic  cfg_val,
    input  logic  op_fin,
    input  logic  fin_limit,
    input  logic  fin_prot,
    input  logic  fin_vpp,
    input  logic  id_exit,
    output logic  cfg_q,
    output hold_e hold_q,
    output logic  kind_prog_q,
    output logic  flt_q,
    output logic  sup_q
);
    logic any_fault;

    assign any_fault = fin_limit || fin_prot || fin_vpp;

    always_ff @(posedge clk) begin
        if (por) begin
            cfg_q       <= 1'b0;
            hold_q      <= HOLD_NONE;
            kind_prog_q <= 1'b0;
            flt_q       <= 1'b0;
            sup_q       <= 1'b0;
        end else if (rst) begin
            hold_q <= HOLD_NONE;
            flt_q  <= 1'b0;
            sup_q  <= 1'b0;
        end else begin
            if (cfg_we)
                cfg_q <= cfg_val;
            if (op_fin) begin
                kind_prog_q <= op_is_prog(op);
                if (any_fault) begin
                    hold_q <= HOLD_FAIL;
                    flt_q  <= fin_limit || fin_prot;
                    sup_q  <= fin_vpp;
                end else begin
                    hold_q <= cfg_q ? HOLD_DONE : HOLD_NONE;
                    flt_q  <= 1'b0;
                    sup_q  <= 1'b0;
                end
            end else if (id_exit) begin
                hold_q <= HOLD_NONE;
                flt_q  <= 1'b0;
                sup_q  <= 1'b0;
            end
        end
    end

    // R10: device reset never alters the configuration
    assert_cfg_keep_R10: assert property (@(posedge clk) disable iff (por)
        rst |=> $stable(cfg_q));

    // R5: a failure stays held until exit or a new finish
    assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (por || rst)
        (hold_q == HOLD_FAIL && !op_fin && !id_exit) |=> (hold_q == HOLD_FAIL));

    // R11: finish beats a simultaneous exit
    assert_fin_wins_R11: assert property (@(posedge clk) disable iff (por || rst)
        (op_fin && id_exit && any_fault) |=> (hold_q == HOLD_FAIL));

    // R6: clean finish in configuration 0 leaves nothing held
    assert_auto_return_R6: assert property (@(posedge clk) disable iff (por || rst)
        (op_fin && !any_fault && !cfg_q) |=> (hold_q == HOLD_NONE));

endmodule

// File: rtl/pe_status_mux.sv
module pe_status_mux
    import pe_status_pkg::*;
(
    input  op_e   op,
    input  logic  in_sector,
    input  logic  last_wr_b7,
    input  logic  cfg_q,
    input  hold_e hold_q,
    input  logic  kind_prog_q,
    input  logic  flt_q,
    input  logic  sup_q,
    input  logic  tog_busy,
    input  logic  tog_erase,
    output sts_t  sts,
    output logic  sel,
    output logic  rdy,
    output logic  adv_busy,
    output logic  adv_erase
);
    logic poll_inv;

    assign poll_inv = ~last_wr_b7;

    always_comb begin
        sts       = '0;
        sel       = 1'b0;
        rdy       = 1'b1;
        adv_busy  = 1'b0;
        adv_erase = 1'b0;
        case (op)
            OP_PROG: begin
                sel       = 1'b1;
                rdy       = 1'b0;
                sts.poll  = cfg_q ? 1'b0 : poll_inv;
                sts.tog   = tog_busy;
                adv_busy  = 1'b1;
            end
            OP_ERASE: begin
                sel       = 1'b1;
                rdy       = 1'b0;
                sts.tog   = tog_busy;
                sts.etog  = tog_erase;
                adv_busy  = 1'b1;
                adv_erase = 1'b1;
            end
            OP_ESUSP: begin
                if (in_sector) begin
                    sel       = 1'b1;
                    sts.poll  = 1'b1;
                    sts.tog   = 1'b1;
                    sts.etog  = tog_erase;
                    adv_erase = 1'b1;
                end
            end
            OP_PSUSP: begin
                if (in_sector) begin
                    sel       = 1'b1;
                    sts.poll  = cfg_q ? 1'b1 : poll_inv;
                    sts.tog   = 1'b1;
                    sts.etog  = tog_erase;
                    adv_erase = 1'b1;
                end
            end
            default: begin
                if (hold_q == HOLD_FAIL) begin
                    sel      = 1'b1;
                    sts.poll = cfg_q ? 1'b1 : (kind_prog_q ? poll_inv : 1'b0);
                    sts.tog  = tog_busy;
                    sts.flt  = flt_q;
                    sts.sup  = sup_q;
                end else if (hold_q == HOLD_DONE) begin
                    sel      = 1'b1;
                    sts.poll = 1'b1;
                    sts.tog  = tog_busy;
                end
            end
        endcase
    end

endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
    import pe_status_pkg::*;
#(
    parameter int STS_W = 8
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst,
    input  logic [2:0]       op_state,
    input  logic             last_wr_b7,
    input  logic             in_sector,
    input  logic             rd_strobe,
    input  logic             op_fin,
    input  logic             fin_limit,
    input  logic             fin_prot,
    input  logic             fin_vpp,
    input  logic             id_exit,
    input  logic             cfg_we,
    input  logic             cfg_val,
    output logic [STS_W-1:0] status_out,
    output logic             sel_status,
    output logic             ready
);
    localparam int PAD_W = STS_W - BYTE_W;

    op_e   op;
    logic  cfg_q;
    hold_e hold_q;
    logic  kind_prog_q;
    logic  flt_q;
    logic  sup_q;
    logic  tog_busy;
    logic  tog_erase;
    logic  adv_busy;
    logic  adv_erase;
    sts_t  sts;
    logic  sel_raw;
    logic  rdy_raw;
    logic [BYTE_W-1:0] byte_w;

    assign op = op_e'(op_state);

    pe_hold_ctl u_hold (
        .clk        (clk),
        .por        (por),
        .rst        (rst),
        .op         (op),
        .cfg_we     (cfg_we),
        .cfg_val    (cfg_val),
        .op_fin     (op_fin),
        .fin_limit  (fin_limit),
        .fin_prot   (fin_prot),
        .fin_vpp    (fin_vpp),
        .id_exit    (id_exit),
        .cfg_q      (cfg_q),
        .hold_q     (hold_q),
        .kind_prog_q(kind_prog_q),
        .flt_q      (flt_q),
        .sup_q      (sup_q)
    );

    pe_rd_toggle u_tog (
        .clk       (clk),
        .por       (por),
        .rst       (rst),
        .rd_strobe (rd_strobe),
        .adv_busy  (adv_busy),
        .adv_erase (adv_erase),
        .tog_busy  (tog_busy),
        .tog_erase (tog_erase)
    );

    pe_status_mux u_mux (
        .op         (op),
        .in_sector  (in_sector),
        .last_wr_b7 (last_wr_b7),
        .cfg_q      (cfg_q),
        .hold_q     (hold_q),
        .kind_prog_q(kind_prog_q),
        .flt_q      (flt_q),
        .sup_q      (sup_q),
        .tog_busy   (tog_busy),
        .tog_erase  (tog_erase),
        .sts        (sts),
        .sel        (sel_raw),
        .rdy        (rdy_raw),
        .adv_busy   (adv_busy),
        .adv_erase  (adv_erase)
    );

    assign byte_w = pack_sts(sts);

    generate
        if (PAD_W > 0) begin : g_pad
            assign status_out = {{PAD_W{1'b0}}, byte_w};
        end else begin : g_exact
            assign status_out = byte_w[STS_W-1:0];
        end
    endgenerate

    assign sel_status = sel_raw;
    assign ready      = rdy_raw;

    // R9: an active program or erase always shows busy
    assert_busy_low_R9: assert property (@(posedge clk) disable iff (por)
        op_running(op) |-> !ready);

    // R7: suspended erase read outside its sector passes array data
    assert_susp_pass_R7: assert property (@(posedge clk) disable iff (por)
        (op == OP_ESUSP && !in_sector) |-> (!sel_status && ready));

    // R5: a held failure never reports busy while idle
    assert_fail_ready_R5: assert property (@(posedge clk) disable iff (por || rst)
        (op == OP_IDLE && hold_q == HOLD_FAIL) |-> (ready && sel_status));

    initial begin
        assert_width_R1: assert (STS_W >= BYTE_W);
    end

endmodule

// File: tb/sim_pe_status_gen.sv
module sim_pe_status_gen;
    localparam int STS_W = 8;

    logic clk = 1'b0;
    logic por = 1'b1, rst = 1'b0;
    logic [2:0] op_state = 3'd0;
    logic last_wr_b7 = 1'b0, in_sector = 1'b0, rd_strobe = 1'b0;
    logic op_fin = 1'b0, fin_limit = 1'b0, fin_prot = 1'b0, fin_vpp = 1'b0;
    logic id_exit = 1'b0, cfg_we = 1'b0, cfg_val = 1'b0;
    logic [STS_W-1:0] status_out;
    logic sel_status, ready;

    int checks = 0, bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pe_status_gen #(.STS_W(STS_W)) u0 (
        .clk(clk), .por(por), .rst(rst), .op_state(op_state),
        .last_wr_b7(last_wr_b7), .in_sector(in_sector), .rd_strobe(rd_strobe),
        .op_fin(op_fin), .fin_limit(fin_limit), .fin_prot(fin_prot),
        .fin_vpp(fin_vpp), .id_exit(id_exit), .cfg_we(cfg_we), .cfg_val(cfg_val),
        .status_out(status_out), .sel_status(sel_status), .ready(ready)
    );

    // reference model state
    bit m_cfg, m_kp, m_f5, m_f3, m_t6, m_t2, m_rdq;
    int m_hold; // 0 none, 1 done-held, 2 fail-held

    function automatic logic [9:0] exp_out();
        logic [7:0] s = '0;
        logic sel = 1'b0, rdy = 1'b1;
        case (op_state)
            3'd1: begin sel = 1; rdy = 0; s[7] = m_cfg ? 1'b0 : ~last_wr_b7; s[6] = m_t6; end
            3'd2: begin sel = 1; rdy = 0; s[6] = m_t6; s[2] = m_t2; end
            3'd3: if (in_sector) begin sel = 1; s[7] = 1; s[6] = 1; s[2] = m_t2; end
            3'd4: if (in_sector) begin sel = 1; s[7] = m_cfg ? 1'b1 : ~last_wr_b7; s[6] = 1; s[2] = m_t2; end
            default: begin
                if (m_hold == 2) begin
                    sel = 1; s[7] = m_cfg ? 1'b1 : (m_kp ? ~last_wr_b7 : 1'b0);
                    s[6] = m_t6; s[5] = m_f5; s[3] = m_f3;
                end else if (m_hold == 1) begin
                    sel = 1; s[7] = 1; s[6] = m_t6;
                end
            end
        endcase
        return {sel, rdy, s};
    endfunction

    task automatic mdl_update();
        bit a6, a2, rise, flt;
        if (por) begin
            m_cfg = 0; m_hold = 0; m_kp = 0; m_f5 = 0; m_f3 = 0; m_t6 = 0; m_t2 = 0; m_rdq = 0;
        end else if (rst) begin
            m_hold = 0; m_f5 = 0; m_f3 = 0; m_t6 = 0; m_t2 = 0; m_rdq = 0;
        end else begin
            a6 = (op_state == 3'd1) || (op_state == 3'd2);
            a2 = (op_state == 3'd2) || (((op_state == 3'd3) || (op_state == 3'd4)) && in_sector);
            rise = rd_strobe && !m_rdq;
            if (rise && a6) m_t6 = ~m_t6;
            if (rise && a2) m_t2 = ~m_t2;
            m_rdq = rd_strobe;
            flt = fin_limit || fin_prot || fin_vpp;
            if (op_fin) begin
                m_kp = (op_state == 3'd1) || (op_state == 3'd4);
                if (flt) begin m_hold = 2; m_f5 = fin_limit || fin_prot; m_f3 = fin_vpp; end
                else begin m_hold = m_cfg ? 1 : 0; m_f5 = 0; m_f3 = 0; end
            end else if (id_exit) begin
                m_hold = 0; m_f5 = 0; m_f3 = 0;
            end
            if (cfg_we) m_cfg = cfg_val;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        mdl_update();
        @(negedge clk);
    endtask

    task automatic fld(string ctx, string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s): got %0b expected %0b", tag, ctx, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        logic [9:0] e = exp_out();
        fld(ctx, m_cfg ? "R2" : "R1", status_out[7], e[7]);
        fld(ctx, "R3", status_out[6], e[6]);
        fld(ctx, "R5", status_out[5], e[5]);
        fld(ctx, "R1", status_out[4], e[4]);
        fld(ctx, "R5", status_out[3], e[3]);
        fld(ctx, "R4", status_out[2], e[2]);
        fld(ctx, "R1", status_out[1], e[1]);
        fld(ctx, "R1", status_out[0], e[0]);
        fld(ctx, "R6", sel_status, e[9]);
        fld(ctx, "R9", ready, e[8]);
    endtask

    task automatic clr_pulses();
        op_fin = 0; fin_limit = 0; fin_prot = 0; fin_vpp = 0;
        id_exit = 0; cfg_we = 0; rst = 0; por = 0;
    endtask

    task automatic reads(int n, string ctx);
        for (int i = 0; i < n; i++) begin
            rd_strobe = 1; cyc(); check_all(ctx);
            rd_strobe = 0; cyc(); check_all(ctx);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(); cyc();
        por = 0; cyc();
        check_all("R10 reset state");

        // programming, configuration 0
        op_state = 3'd1; last_wr_b7 = 1; cyc(); check_all("R1 program polling d7=1");
        last_wr_b7 = 0; cyc(); check_all("R1 program polling d7=0");
        reads(3, "R3 R4 program toggles");
        op_state = 3'd0; op_fin = 1; cyc(); clr_pulses(); check_all("R6 auto return");
        // erase
        op_state = 3'd2; cyc(); check_all("R1 erase polling");
        reads(3, "R4 erase toggles");
        // protect fault
        op_state = 3'd0; op_fin = 1; fin_prot = 1; cyc(); clr_pulses(); check_all("R5 protect fault");
        reads(2, "R3 frozen after end");
        id_exit = 1; cyc(); clr_pulses(); check_all("R5 exit after fault");
        // configuration 1
        cfg_we = 1; cfg_val = 1; cyc(); clr_pulses();
        op_state = 3'd1; reads(2, "R2 program busy");
        op_state = 3'd0; op_fin = 1; cyc(); clr_pulses(); check_all("R2 R6 done held");
        cyc(); check_all("R6 still held");
        id_exit = 1; cyc(); clr_pulses(); check_all("R6 exit done");
        op_state = 3'd2; cyc(); op_state = 3'd0; op_fin = 1; fin_vpp = 1; cyc(); clr_pulses();
        check_all("R5 supply fault cfg1");
        id_exit = 1; cyc(); clr_pulses();
        // suspend cases
        op_state = 3'd3; in_sector = 1; reads(3, "R7 erase suspend in sector");
        in_sector = 0; reads(1, "R7 erase suspend other sector");
        op_state = 3'd4; in_sector = 1; last_wr_b7 = 1; reads(2, "R8 program suspend cfg1");
        cfg_we = 1; cfg_val = 0; cyc(); clr_pulses(); check_all("R8 program suspend cfg0");
        in_sector = 0; cyc(); check_all("R8 program suspend other sector");
        // finish and exit together
        op_state = 3'd0; op_fin = 1; fin_limit = 1; id_exit = 1; cyc(); clr_pulses();
        check_all("R11 finish beats exit");
        // reset keeps configuration
        cfg_we = 1; cfg_val = 1; cyc(); clr_pulses();
        rst = 1; cfg_we = 1; cfg_val = 0; cyc(); clr_pulses(); check_all("R10 rst clears hold");
        op_state = 3'd1; last_wr_b7 = 0; cyc(); check_all("R10 cfg kept over rst");
        por = 1; cyc(); clr_pulses(); cyc(); check_all("R10 por clears cfg");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            op_state   = 3'($urandom % 5);
            in_sector  = 1'($urandom % 2);
            last_wr_b7 = 1'($urandom % 2);
            rd_strobe  = 1'($urandom % 2);
            op_fin     = ($urandom % 8) == 0;
            fin_limit  = op_fin && (($urandom % 4) == 0);
            fin_prot   = op_fin && (($urandom % 4) == 0);
            fin_vpp    = op_fin && (($urandom % 4) == 0);
            id_exit    = ($urandom % 6) == 0;
            cfg_we     = ($urandom % 20) == 0;
            cfg_val    = 1'($urandom % 2);
            rst        = ($urandom % 60) == 0;
            cyc();
            check_all(op_fin && id_exit ? "R11 random overlap" : "random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule